// File: doc/BRIEF.md
# Dual-Channel Converter Overrange Flagger

This block sits right behind a 12-bit sampling converter and watches both of its channels for samples that approach or hit full scale. Each accepted sample is read as a signed value. It is reinterpreted first if the stream uses offset-binary coding. The block then folds the value to a saturating 11-bit magnitude, and the top 8 bits of that magnitude are compared against two programmable levels. The lower level gives an early "near saturation" warning. The upper level flags a sample at or over the limit.

Both channels share the same pair of levels. Every flag has a short fixed latency, so gain-management logic can act on it quickly. Each flag also has a programmable stretch, which keeps a one-sample event visible to slower logic. The levels are loaded through a simple write strobe with a one-bit selector.

Top module: `range_guard`

## Requirements
- R1: With `fmtOffset` = 1 the sample's MSB is inverted before anything else, so code 0x000 is read as -2048, 0x800 as zero and 0xFFF as +2047. With `fmtOffset` = 0 the sample is read as two's complement.
- R2: The magnitude saturates. The two's-complement input 0x800 (-2048) yields magnitude 2047, which gives a compared value of 255. It never wraps to zero.
- R3: The compared value is bits [10:3] of the 11-bit magnitude. Magnitudes 2032 to 2039 give 254, and magnitudes 2040 to 2047 give 255.
- R4: Flag bit 0 of a channel relates to level 0 and flag bit 1 relates to level 1. A flag sets when the compared value is greater than or equal to its level.
- R5: Channel A (`flagA`) and channel B (`flagB`) are compared against the same two level registers.
- R6: A sample applied with `sampleValid` = 1 before clock edge k shows its flags after edge k+1 and not earlier. A cycle with `sampleValid` = 0 never sets a flag.
- R7: After the last exceeding sample, a flag stays high for `holdLen` + 1 clock cycles and then clears. `holdLen` is sampled when the exceeding sample is compared.
- R8: A write with `thrWrEn` = 1 loads `thrData` into level 0 (`thrSel` = 0) or level 1 (`thrSel` = 1). The new level applies to every sample accepted at the same edge or later.
- R9: Reset sets both levels to 255 and clears all flags and stretch counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtOffset | input | 1 | 1 = offset-binary samples, 0 = two's complement |
| sampleValid | input | 1 | Samples on both channels are valid this cycle |
| sampleA | input | 12 | Channel A sample |
| sampleB | input | 12 | Channel B sample |
| thrWrEn | input | 1 | Level write strobe |
| thrSel | input | 1 | Level select for the write (0 or 1) |
| thrData | input | 8 | Level value to write |
| holdLen | input | 8 | Flag stretch length in cycles |
| flagA | output | 2 | Channel A flags, bit 0 = level 0, bit 1 = level 1 |
| flagB | output | 2 | Channel B flags, same layout |

## Verification
The assertions assume that `fmtOffset` changes only while no sample is in flight. They also assume that `thrSel` is a plain 0 or 1 with no unknown value whenever `thrWrEn` is high. The stimulus respects both: the format is switched only after idle cycles, and every write drives a defined selector. Random traffic mixes valid and idle cycles and level writes that land on the same edge as samples, so the same-edge rule for levels and the stretch restart are exercised under load.

// File: rtl/range_guard_pkg.sv
package range_guard_pkg;
  parameter int SAMPLE_W = 12;
  parameter int KEEP_W   = 8;
  parameter int NUM_CH   = 2;
  parameter int NUM_THR  = 2;
  parameter int HOLD_W   = 8;
  localparam int MAG_W   = SAMPLE_W - 1;
  localparam int DROP_W  = MAG_W - KEEP_W;
  localparam int SEL_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;

  typedef struct packed {
    logic capture;   // stage 1 loads magnitudes
    logic compare;   // stage 2 evaluates levels
  } rgStrobe_t;
endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import range_guard_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sampleValid,
  input  logic                            thrWrEn,
  input  logic [SEL_W-1:0]                thrSel,
  input  logic [KEEP_W-1:0]               thrData,
  output rgStrobe_t                       stb,
  output logic [NUM_THR-1:0][KEEP_W-1:0]  thrQ
);
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= sampleValid;
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_lvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    thrQ[t] <= '1;
      else if (thrWrEn && (thrSel == SEL_W'(t)))    thrQ[t] <= thrData;
    end
  end

  assign stb.capture = sampleValid;
  assign stb.compare = validQ;
endmodule

// File: rtl/rg_datapath.sv
module rg_datapath
  import range_guard_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  rgStrobe_t                        stb,
  input  logic                             fmtOffset,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  samples,
  input  logic [NUM_THR-1:0][KEEP_W-1:0]   thrQ,
  input  logic [HOLD_W-1:0]                holdLen,
  output logic [NUM_CH-1:0][KEEP_W-1:0]    magQ,
  output logic [NUM_CH-1:0][NUM_THR-1:0]   flags
);
  function automatic logic [MAG_W-1:0] satMag(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] neg;
    neg = ~s + 1'b1;
    if (!s[SAMPLE_W-1])      return s[MAG_W-1:0];
    else if (neg[SAMPLE_W-1]) return '1;          // most negative code
    else                      return neg[MAG_W-1:0];
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] signedView;
    logic [MAG_W-1:0]    magFull;

    assign signedView = fmtOffset ? {~samples[c][SAMPLE_W-1], samples[c][SAMPLE_W-2:0]}
                                  : samples[c];
    assign magFull    = satMag(signedView);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            magQ[c] <= '0;
      else if (stb.capture) magQ[c] <= magFull[MAG_W-1:DROP_W];
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_lvl
      logic              hit;
      logic [HOLD_W-1:0] holdCnt;

      assign hit = stb.compare && (magQ[c] >= thrQ[t]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdCnt     <= '0;
          flags[c][t] <= 1'b0;
        end else if (hit) begin
          holdCnt     <= holdLen;
          flags[c][t] <= 1'b1;
        end else if (holdCnt != '0) begin
          holdCnt     <= holdCnt - 1'b1;
          flags[c][t] <= 1'b1;
        end else begin
          flags[c][t] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/range_guard.sv
module range_guard
  import range_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                fmtOffset,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic                thrWrEn,
  input  logic [SEL_W-1:0]    thrSel,
  input  logic [KEEP_W-1:0]   thrData,
  input  logic [HOLD_W-1:0]   holdLen,
  output logic [NUM_THR-1:0]  flagA,
  output logic [NUM_THR-1:0]  flagB
);
  rgStrobe_t                        stb;
  logic [NUM_THR-1:0][KEEP_W-1:0]   thrQ;
  logic [NUM_CH-1:0][KEEP_W-1:0]    magQ;
  logic [NUM_CH-1:0][NUM_THR-1:0]   flags;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]  samples;

  assign samples[0] = sampleA;
  assign samples[1] = sampleB;

  rg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .thrWrEn(thrWrEn), .thrSel(thrSel), .thrData(thrData),
    .stb(stb), .thrQ(thrQ)
  );

  rg_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .fmtOffset(fmtOffset),
    .samples(samples), .thrQ(thrQ), .holdLen(holdLen),
    .magQ(magQ), .flags(flags)
  );

  assign flagA = flags[0];
  assign flagB = flags[1];
endmodule

// File: rtl/range_guard_chk.sv
module range_guard_chk
  import range_guard_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            fmtOffset,
  input logic                            sampleValid,
  input logic [SAMPLE_W-1:0]             sampleA,
  input logic                            thrWrEn,
  input logic [SEL_W-1:0]                thrSel,
  input logic [KEEP_W-1:0]               thrData,
  input rgStrobe_t                       stb,
  input logic [NUM_THR-1:0][KEEP_W-1:0]  thrQ,
  input logic [NUM_CH-1:0][KEEP_W-1:0]   magQ,
  input logic [NUM_THR-1:0]              flagA,
  input logic [NUM_THR-1:0]              flagB
);
  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (thrQ[0] == '1 && thrQ[1] == '1 && flagA == '0 && flagB == '0));

  a_r8_level0_load: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrEn && thrSel == '0) |=> thrQ[0] == $past(thrData));

  a_r8_levels_keep: assert property (@(posedge clk) disable iff (!rstN)
    !thrWrEn |=> $stable(thrQ));

  a_r2_min_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !fmtOffset && sampleA == 12'h800) |=> magQ[0] == '1);

  a_r1_offset_midcode: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && fmtOffset && sampleA == 12'h800) |=> magQ[0] == '0);

  a_r4_ge_sets: assert property (@(posedge clk) disable iff (!rstN)
    (stb.compare && magQ[0] >= thrQ[0]) |=> flagA[0]);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.compare && !flagB[1]) |=> !flagB[1]);
endmodule

bind range_guard range_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .fmtOffset(fmtOffset), .sampleValid(sampleValid),
  .sampleA(sampleA), .thrWrEn(thrWrEn), .thrSel(thrSel), .thrData(thrData),
  .stb(stb), .thrQ(thrQ), .magQ(magQ), .flagA(flagA), .flagB(flagB)
);

// File: tb/range_guard_tb_top.sv
module range_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fmtOffset = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleA = '0, sampleB = '0;
  logic        thrWrEn = 1'b0;
  logic        thrSel = 1'b0;
  logic [7:0]  thrData = '0;
  logic [7:0]  holdLen = '0;
  logic [1:0]  flagA, flagB;

  int checks = 0, failures = 0, cyc = 0;
  bit compareOn = 0;
  string phase = "R9 reset";

  // reference state
  int  mThr[2];
  int  pMag[2];
  bit  pValid;
  int  cnt[2][2];
  bit  ef[2][2];

  always #10 clk = ~clk;

  range_guard dut_i (
    .clk(clk), .rstN(rstN), .fmtOffset(fmtOffset), .sampleValid(sampleValid),
    .sampleA(sampleA), .sampleB(sampleB), .thrWrEn(thrWrEn), .thrSel(thrSel),
    .thrData(thrData), .holdLen(holdLen), .flagA(flagA), .flagB(flagB)
  );

  function automatic int topOf(input logic [11:0] x, input bit offs);
    int v, m;
    if (offs) v = int'(x) - 2048;
    else      v = (x >= 12'd2048) ? int'(x) - 4096 : int'(x);
    m = (v < 0) ? -v : v;
    if (m > 2047) m = 2047;
    return m / 8;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mThr[i] = 255; pMag[i] = 0;
      for (int j = 0; j < 2; j++) begin cnt[i][j] = 0; ef[i][j] = 0; end
    end
    pValid = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      for (int c = 0; c < 2; c++)
        for (int t = 0; t < 2; t++) begin
          if (pValid && pMag[c] >= mThr[t]) begin ef[c][t] = 1; cnt[c][t] = int'(holdLen); end
          else if (cnt[c][t] > 0) begin cnt[c][t]--; ef[c][t] = 1; end
          else ef[c][t] = 0;
        end
      if (thrWrEn) mThr[thrSel] = int'(thrData);
      pValid = sampleValid;
      if (sampleValid) begin
        pMag[0] = topOf(sampleA, fmtOffset);
        pMag[1] = topOf(sampleB, fmtOffset);
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (compareOn) begin
      logic [3:0] expv;
      expv = {ef[1][1], ef[1][0], ef[0][1], ef[0][0]};
      checks++;
      if ({flagB, flagA} !== expv) begin
        failures++;
        $display("FAIL %s: flags actual=%b expected=%b at cycle %0d", phase, {flagB, flagA}, expv, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sample, optional same-edge level write; returns flags after edge k+1
  task automatic pulse(input logic [11:0] a, input logic [11:0] b, input bit doWr,
                       input bit sel, input logic [7:0] val,
                       output logic [1:0] fa, output logic [1:0] fb);
    sampleA = a; sampleB = b; sampleValid = 1'b1;
    thrWrEn = doWr; thrSel = sel; thrData = val;
    @(negedge clk);
    sampleValid = 1'b0; thrWrEn = 1'b0;
    chk("R6 latency A", flagA, 2'b00);
    chk("R6 latency B", flagB, 2'b00);
    @(negedge clk);
    fa = flagA; fb = flagB;
  endtask

  task automatic wrLvl(input bit sel, input logic [7:0] val);
    thrWrEn = 1'b1; thrSel = sel; thrData = val;
    @(negedge clk);
    thrWrEn = 1'b0;
  endtask

  initial begin
    logic [1:0] fa, fb;
    int highCnt;
    idle(3);
    chk("R9 reset A", flagA, 2'b00);
    chk("R9 reset B", flagB, 2'b00);
    rstN = 1'b1;
    compareOn = 1;
    idle(2);

    phase = "R9 default levels";
    pulse(12'h7F7, 12'h7F7, 0, 0, 0, fa, fb);   // 2039 -> 254 < 255
    chk("R9 default level A", fa, 2'b00);
    idle(2);
    pulse(12'h7F8, 12'h7FF, 0, 0, 0, fa, fb);   // 2040 -> 255
    chk("R3 2040 gives 255", fa, 2'b11);
    chk("R3 2047 gives 255", fb, 2'b11);
    idle(2);

    phase = "R2 saturation";
    pulse(12'h800, 12'h800, 0, 0, 0, fa, fb);
    chk("R2 -2048 saturates A", fa, 2'b11);
    chk("R2 -2048 saturates B", fb, 2'b11);
    idle(2);

    phase = "R3 truncation";
    wrLvl(0, 8'd254);
    pulse(12'h7F7, 12'h809, 0, 0, 0, fa, fb);   // +2039, -2039 -> 254
    chk("R3 2039 gives 254 A", fa, 2'b01);
    chk("R5 shared levels B", fb, 2'b01);
    idle(2);
    pulse(12'h7EF, 12'h000, 0, 0, 0, fa, fb);   // 2031 -> 253
    chk("R3 2031 gives 253", fa, 2'b00);
    chk("R5 zero on B", fb, 2'b00);
    idle(2);

    phase = "R1 offset binary";
    fmtOffset = 1'b1;
    idle(1);
    pulse(12'h000, 12'h800, 0, 0, 0, fa, fb);
    chk("R1 code 0 is -2048", fa, 2'b11);
    chk("R1 code 0x800 is zero", fb, 2'b00);
    idle(2);
    pulse(12'hFFF, 12'h7F8, 0, 0, 0, fa, fb);   // +2047 ; -8 -> 1
    chk("R1 code 0xFFF is +2047", fa, 2'b11);
    chk("R1 near zero", fb, 2'b00);
    idle(2);
    fmtOffset = 1'b0;
    idle(1);

    phase = "R4 greater or equal";
    wrLvl(1, 8'd100);
    pulse(12'd800, 12'd799, 0, 0, 0, fa, fb);   // 100 and 99
    chk("R4 equal sets", fa, 2'b10);
    chk("R4 below clear", fb, 2'b00);
    idle(2);

    phase = "R8 same-edge write";
    pulse(12'd96, 12'd88, 1, 0, 8'd12, fa, fb);  // tops 12 and 11
    chk("R8 new level applies A", fa, 2'b01);
    chk("R8 new level applies B", fb, 2'b00);
    idle(2);

    phase = "R6 invalid ignored";
    sampleA = 12'h7FF; sampleB = 12'h800; sampleValid = 1'b0;
    idle(3);
    chk("R6 invalid A", flagA, 2'b00);
    chk("R6 invalid B", flagB, 2'b00);

    phase = "R7 stretch";
    holdLen = 8'd3;
    pulse(12'h7FF, 12'h0, 0, 0, 0, fa, fb);
    holdLen = 8'd0;
    highCnt = 0;
    while (flagA[1] && highCnt < 20) begin highCnt++; @(negedge clk); end
    checks++;
    if (highCnt != 4) begin
      failures++;
      $display("FAIL R7 stretch length: actual=%0d expected=4", highCnt);
    end
    idle(2);

    phase = "R1-R9 random";
    for (int i = 0; i < 3000; i++) begin
      sampleValid = ($urandom_range(0, 3) != 0);
      sampleA = 12'($urandom);
      sampleB = ($urandom_range(0, 1) != 0) ? 12'($urandom_range(0, 15) + 12'h7F0) : 12'($urandom);
      thrWrEn = ($urandom_range(0, 15) == 0);
      thrSel = 1'($urandom);
      thrData = 8'($urandom_range(180, 255));
      holdLen = 8'($urandom_range(0, 6));
      if (i == 1500) begin
        sampleValid = 1'b0; thrWrEn = 1'b0;
        idle(3);
        fmtOffset = 1'b1;
      end
      @(negedge clk);
    end
    sampleValid = 1'b0; thrWrEn = 1'b0;
    idle(12);
    compareOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule